// File: doc/BRIEF.md
# Dual-Half Iterative Multiplier

This block multiplies two 32-bit words over many clock cycles with one adder per product half, not a full array. A single loop of 32 steps builds two results at once. The lower word of the product is built by shifting an accumulator left and adding the multiplicand when the top bit of the multiplier is set. The upper unsigned word is built by adding the multiplicand when the bottom bit of the multiplier is set, then shifting right with the saved carry placed into the top bit. After the loop, two optional subtraction steps turn the unsigned upper word into its signed-by-unsigned or signed-by-signed form.

A 6-bit operation code picks which word comes out. An immediate flag turns the request into a low-word multiply whose second operand is the sign-extended lower 16 bits of the second operand input. A one-cycle `start_i` launches a run when the block is idle. `done_o` pulses once when the result is ready. The result then stays on `result_o` until the next accepted start.

Top module: `mulx_iter_top`

## Requirements
- R1: While reset is held, and after it is released with no start, `busy_o` and `done_o` are low.
- R2: Operation code 0x27 returns bits 31:0 of the product of the operands.
- R3: Operation code 0x07 returns bits 63:32 of the product, with both operands taken as unsigned.
- R4: Operation code 0x17 returns bits 63:32 of the product, with `opa_i` taken as two's complement and `opb_i` taken as unsigned.
- R5: Operation code 0x1f returns bits 63:32 of the product, with both operands taken as two's complement.
- R6: With `imm_mode_i` high, the second operand is `opb_i[15:0]` sign-extended to 32 bits, and the low-word multiply is performed whatever `op_i` holds. `opb_i[31:16]` has no effect.
- R7: Any operation code other than 0x27, 0x07 and 0x17 gives the same result as 0x1f.
- R8: `done_o` is high for exactly one cycle, 34 rising edges after the edge that samples `start_i`. `busy_o` is high from the edge after that sample up to the cycle in which `done_o` rises, and is never high at the same time as `done_o`.
- R9: A start is accepted only while `busy_o` and `done_o` are both low. A start pulse during a run changes neither the result nor the timing of that run.
- R10: After `done_o`, `result_o` keeps its value until the next accepted start, even if the operand and code inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to begin a multiply |
| op_i | input | 6 | Operation code selecting the result word |
| imm_mode_i | input | 1 | Immediate form: sign-extend opb_i[15:0] and use the low-word multiply |
| opa_i | input | 32 | First operand (multiplicand) |
| opb_i | input | 32 | Second operand (multiplier) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse: result_o is valid |
| result_o | output | 32 | Selected product word |

## Verification
Each mode is run on small positive operands, on mixed-magnitude operands, on zero, and on the two extreme values 0x80000000 and 0xFFFFFFFF, each paired with itself and with the other. The extreme pairs separate the three upper-word modes. They change only through the correction subtractions: the first subtraction shows up only when the first operand is negative, and the second only when the second operand is negative. Immediate tests put a negative 16-bit constant under nonzero upper bits together with a conflicting operation code. This shows whether sign extension replaces those bits and whether the code is overridden. Unknown codes, a start pulse in the middle of a run, and input changes after completion show whether the decode fallback, the busy guard and the result hold are in place.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
  typedef enum logic [1:0] {
    SEL_LOW,
    SEL_UU,
    SEL_SU,
    SEL_SS
  } mul_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOP,
    ST_FIX_SU,
    ST_FIX_SS,
    ST_FINISH
  } mul_state_e;

  localparam logic [5:0] OPC_LOW = 6'h27;
  localparam logic [5:0] OPC_UU  = 6'h07;
  localparam logic [5:0] OPC_SU  = 6'h17;
endpackage

// File: rtl/mulx_operand_prep.sv
module mulx_operand_prep
  import mulx_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  parameter int OPC_W = 6
) (
  input  logic [OPC_W-1:0] op_i,
  input  logic             imm_mode_i,
  input  logic [WIDTH-1:0] opb_i,
  output mul_sel_e         sel_o,
  output logic [WIDTH-1:0] opb_eff_o
);
  logic [WIDTH-1:0] imm_ext;

  generate
    if (IMM_W < WIDTH) begin : g_ext
      assign imm_ext = {{(WIDTH-IMM_W){opb_i[IMM_W-1]}}, opb_i[IMM_W-1:0]};
    end else begin : g_full
      assign imm_ext = opb_i;
    end
  endgenerate

  always_comb begin
    if (imm_mode_i) begin
      sel_o = SEL_LOW;
    end else if (op_i == OPC_W'(OPC_LOW)) begin
      sel_o = SEL_LOW;
    end else if (op_i == OPC_W'(OPC_UU)) begin
      sel_o = SEL_UU;
    end else if (op_i == OPC_W'(OPC_SU)) begin
      sel_o = SEL_SU;
    end else begin
      sel_o = SEL_SS; // R7: fallback for every other code
    end
    opb_eff_o = imm_mode_i ? imm_ext : opb_i;
  end
endmodule

// File: rtl/mulx_ctrl.sv
module mulx_ctrl
  import mulx_pkg::*;
#(
  parameter int ITER = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fix_su_o,
  output logic fix_ss_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LOOP;
          cnt_d   = '0;
        end
      end
      ST_LOOP: begin
        if (cnt_q == LAST) begin
          state_d = ST_FIX_SU;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FIX_SU: state_d = ST_FIX_SS;
      ST_FIX_SS: state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign step_o   = (state_q == ST_LOOP);
  assign fix_su_o = (state_q == ST_FIX_SU);
  assign fix_ss_o = (state_q == ST_FIX_SS);
  assign done_o   = (state_q == ST_FINISH);
  assign busy_o   = (state_q != ST_IDLE) && (state_q != ST_FINISH);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  a_r8_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && cnt_q != LAST) |=> (step_o && cnt_q == $past(cnt_q) + 1'b1));
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (state_q != ST_LOOP || cnt_q != '0));
endmodule

// File: rtl/mulx_loop_core.sv
module mulx_loop_core
  import mulx_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             fix_su_i,
  input  logic             fix_ss_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  mul_sel_e         sel_i,
  output logic [WIDTH-1:0] result_o
);
  logic [WIDTH-1:0] a_q, a_d, b_q, b_d;
  logic [WIDTH-1:0] ml_q, ml_d, mr_q, mr_d;
  logic [WIDTH-1:0] lo_q, lo_d, hi_q, hi_d;
  mul_sel_e         sel_q, sel_d;
  logic [WIDTH:0]   hsum;
  logic             en;

  assign en = load_i | step_i | fix_su_i | fix_ss_i;

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    ml_d  = ml_q;
    mr_d  = mr_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    sel_d = sel_q;
    hsum  = '0;
    if (load_i) begin
      a_d   = opa_i;
      b_d   = opb_i;
      ml_d  = opb_i;
      mr_d  = opb_i;
      lo_d  = '0;
      hi_d  = '0;
      sel_d = sel_i;
    end else if (step_i) begin
      lo_d = {lo_q[WIDTH-2:0], 1'b0} + (ml_q[WIDTH-1] ? a_q : '0);
      ml_d = {ml_q[WIDTH-2:0], 1'b0};
      hsum = {1'b0, hi_q} + {1'b0, (mr_q[0] ? a_q : '0)};
      hi_d = hsum[WIDTH:1];
      mr_d = {1'b0, mr_q[WIDTH-1:1]};
    end else if (fix_su_i) begin
      if ((sel_q == SEL_SU || sel_q == SEL_SS) && a_q[WIDTH-1]) begin
        hi_d = hi_q - b_q;
      end
    end else if (fix_ss_i) begin
      if (sel_q == SEL_SS && b_q[WIDTH-1]) begin
        hi_d = hi_q - a_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      ml_q  <= '0;
      mr_q  <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      sel_q <= SEL_LOW;
    end else if (en) begin
      a_q   <= a_d;
      b_q   <= b_d;
      ml_q  <= ml_d;
      mr_q  <= mr_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      sel_q <= sel_d;
    end
  end

  assign result_o = (sel_q == SEL_LOW) ? lo_q : hi_q;

  a_r2_copies_drained: assert property (@(posedge clk) disable iff (!rst_n)
    fix_su_i |-> (ml_q == '0 && mr_q == '0));
  a_r9_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(a_q) && $stable(b_q) && $stable(sel_q)));
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(result_o));
  a_r5_no_fix_when_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_ss_i && !b_q[WIDTH-1]) |=> $stable(hi_q));
endmodule

// File: rtl/mulx_iter_top.sv
module mulx_iter_top
  import mulx_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  parameter int OPC_W = 6,
  parameter int ITER  = WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OPC_W-1:0] op_i,
  input  logic             imm_mode_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             load, step, fix_su, fix_ss;
  mul_sel_e         sel;
  logic [WIDTH-1:0] opb_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  mulx_operand_prep #(.WIDTH(WIDTH), .IMM_W(IMM_W), .OPC_W(OPC_W)) u_prep (
    .op_i       (op_i),
    .imm_mode_i (imm_mode_i),
    .opb_i      (opb_i),
    .sel_o      (sel),
    .opb_eff_o  (opb_eff)
  );

  mulx_ctrl #(.ITER(ITER)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (start_i),
    .load_o   (load),
    .step_o   (step),
    .fix_su_o (fix_su),
    .fix_ss_o (fix_ss),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  mulx_loop_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_i   (load),
    .step_i   (step),
    .fix_su_i (fix_su),
    .fix_ss_i (fix_ss),
    .opa_i    (opa_i),
    .opb_i    (opb_eff),
    .sel_i    (sel),
    .result_o (result_o)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (!busy_o && !done_o));
endmodule

// File: tb/sim_mulx_iter_top.sv
`timescale 1ns/1ps
module sim_mulx_iter_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [5:0]  opc;
  logic        immm;
  logic [31:0] opa, opb;
  logic        busy_o, done_o;
  logic [31:0] result_o;
  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  mulx_iter_top u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(opc), .imm_mode_i(immm),
    .opa_i(opa), .opb_i(opb), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  function automatic logic [63:0] prod_uu(input logic [31:0] a, b);
    return {32'b0, a} * {32'b0, b};
  endfunction
  function automatic logic [63:0] prod_su(input logic [31:0] a, b);
    logic signed [63:0] x, y;
    x = {{32{a[31]}}, a};
    y = {32'b0, b};
    return x * y;
  endfunction
  function automatic logic [63:0] prod_ss(input logic [31:0] a, b);
    logic signed [63:0] x, y;
    x = {{32{a[31]}}, a};
    y = {{32{b[31]}}, b};
    return x * y;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run(output logic [31:0] res, output int lat);
    int n = 0;
    while (!done_o && n < 60) begin
      @(negedge clk);
      if (busy_o === 1'b0 && !done_o) n = 100; // R8: busy dropped early
      n++;
    end
    lat = n;
    res = result_o;
    @(negedge clk);
    chk("R8 done single pulse", {31'b0, done_o}, 32'd0);
  endtask

  task automatic launch(input logic [31:0] a, b, input logic [5:0] op, input logic imm,
                        output logic [31:0] res);
    int lat;
    @(negedge clk);
    opa = a; opb = b; opc = op; immm = imm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", {31'b0, busy_o}, 32'd1);
    finish_run(res, lat);
    chk("R8 latency", lat, 32'd34);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; opc = 6'h0; immm = 1'b0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'b0, busy_o}, 32'd0);
    chk("R1 done in reset", {31'b0, done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", {31'b0, busy_o}, 32'd0);
    chk("R1 done after reset", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_modes(input logic [31:0] a, b);
    logic [31:0] r;
    launch(a, b, 6'h27, 1'b0, r); chk("R2 low word", r, prod_uu(a, b)[31:0]);
    launch(a, b, 6'h07, 1'b0, r); chk("R3 uu high", r, prod_uu(a, b)[63:32]);
    launch(a, b, 6'h17, 1'b0, r); chk("R4 su high", r, prod_su(a, b)[63:32]);
    launch(a, b, 6'h1f, 1'b0, r); chk("R5 ss high", r, prod_ss(a, b)[63:32]);
  endtask

  task automatic t_imm();
    logic [31:0] r;
    launch(32'h0000_0007, 32'hABCD_8000, 6'h07, 1'b1, r);
    chk("R6 imm negative", r, prod_uu(32'h7, 32'hFFFF_8000)[31:0]);
    launch(32'h8000_0001, 32'h5555_7FFF, 6'h1f, 1'b1, r);
    chk("R6 imm positive", r, prod_uu(32'h8000_0001, 32'h0000_7FFF)[31:0]);
  endtask

  task automatic t_unknown();
    logic [31:0] r;
    launch(32'h8000_0000, 32'hFFFF_FFFF, 6'h00, 1'b0, r);
    chk("R7 code 00", r, prod_ss(32'h8000_0000, 32'hFFFF_FFFF)[63:32]);
    launch(32'hF000_0003, 32'h8765_4321, 6'h3f, 1'b0, r);
    chk("R7 code 3f", r, prod_ss(32'hF000_0003, 32'h8765_4321)[63:32]);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] r;
    int lat;
    @(negedge clk);
    opa = 32'h1234_5678; opb = 32'h9ABC_DEF0; opc = 6'h07; immm = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    opa = 32'hFFFF_FFFF; opb = 32'hFFFF_FFFF; opc = 6'h27; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int n = 5;
      while (!done_o && n < 60) begin @(negedge clk); n++; end
      lat = n;
    end
    r = result_o;
    chk("R9 result unchanged", r, prod_uu(32'h1234_5678, 32'h9ABC_DEF0)[63:32]);
    chk("R9 timing unchanged", lat, 32'd34);
    @(negedge clk);
    chk("R9 no second run", {31'b0, busy_o}, 32'd0);
  endtask

  task automatic t_hold();
    logic [31:0] r;
    launch(32'hDEAD_BEEF, 32'h0BAD_F00D, 6'h17, 1'b0, r);
    opa = 32'h1; opb = 32'h1; opc = 6'h27; immm = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 result held", result_o, prod_su(32'hDEAD_BEEF, 32'h0BAD_F00D)[63:32]);
    chk("R10 stays idle", {31'b0, busy_o}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_modes(32'd3, 32'd5);
    t_modes(32'h8000_0000, 32'h8000_0000);
    t_modes(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_modes(32'h8000_0000, 32'hFFFF_FFFF);
    t_modes(32'hFFFF_FFFF, 32'h8000_0000);
    t_modes(32'h1234_5678, 32'h9ABC_DEF0);
    t_modes(32'h0, 32'hFFFF_FFFF);
    t_imm();
    t_unknown();
    t_busy_ignore();
    t_hold();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule